// File: doc/BRIEF.md
# Bit-Serial Register Adder with Step Sequencer

This block adds two 4-bit operands one bit per clock. It holds three registers: two operand registers (A and B) and a result register (C). A 3-bit step counter sets the phase of the work. Steps 0, 1 and 2 are load slots for A, B and C in that order. During steps 3 to 6, A and B rotate right one place per clock, and C shifts right. A one-bit full adder combines the low bits of A and B with a registered carry, and its sum bit enters C at the top. When the counter reaches step 7, C holds the 4-bit sum, and A and B have rotated back to their loaded values.

In use, the sequence is as follows:

1. Pulse the clear input.
2. Hold the count enable high.
3. Present operand A on the shared data bus with its load strobe in step 0.
4. Present operand B on the bus with its strobe in step 1.
5. Optionally preload C in step 2.
6. Keep the enable high through the four add steps, which need one clock each.

The carry out of the top bit stays in the carry flip-flop as a separate output.

Top module: `serial_adder_seq`

## Requirements
- R1: While `clear_n` is low at a rising clock edge, the step counter, all three registers and the carry flip-flop become 0 after that edge.
- R2: The step counter increments by one (wrapping 7 to 0) on each clock edge when `count_en` is high, and holds when it is low.
- R3: In step 0 with `load_a` high, A takes `data_in` at the clock edge, on every such edge, whether or not the counter moves. In all other steps `load_a` is ignored.
- R4: In step 1 with `load_b` high, B takes `data_in`. In all other steps `load_b` is ignored.
- R5: In step 2 with `load_c` high, C takes `data_in`. In all other steps `load_c` is ignored.
- R6: In each of steps 3 to 6, A and B rotate right one place per edge: old bit 0 moves to bit 3. All load strobes are ignored in these steps.
- R7: In each of steps 3 to 6, C shifts right one place and its bit 3 takes A[0] xor B[0] xor carry, using the values held before that edge. Old bit 0 of C is dropped.
- R8: After a clear, loads in steps 0 and 1, and four consecutive add steps, at step 7 C equals (A+B) mod 16 and A and B equal their loaded values.
- R9: The carry flip-flop updates only in steps 3 to 6. After the run it holds the carry out of bit 3 of A+B through step 7 and later steps, until clear.
- R10: In steps 0, 1, 2 and 7, a register with no load active keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on the rising edge |
| clear_n | input | 1 | Synchronous clear, active low |
| count_en | input | 1 | Step counter advance enable |
| load_a | input | 1 | Load strobe for register A (acts in step 0) |
| load_b | input | 1 | Load strobe for register B (acts in step 1) |
| load_c | input | 1 | Load strobe for register C (acts in step 2) |
| data_in | input | 4 | Shared parallel load data |
| reg_a | output | 4 | Register A value |
| reg_b | output | 4 | Register B value |
| reg_c | output | 4 | Result register C value |
| step | output | 3 | Current step number |
| carry_out | output | 1 | Registered carry of the serial adder |

## Verification
Two pairs of functions can land in the same cycle. First, a load strobe can arrive while an add step is shifting the registers. Second, a repeated load in step 0 can occur while the counter is stalled. The bench covers both cases:

- It raises all three strobes with random bus data during every add step in some runs, and expects the rotation and shift to win.
- In other runs it holds the counter at step 0 for one edge with a decoy value on the bus, then reloads the true operand as the counter moves. It expects A to follow the bus on both edges.

A behavioural model predicts every output on every clock. All 256 operand pairs are also judged at step 7 against plain integer addition.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  // Per-register action chosen from the {step, strobe} index
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } reg_op_e;

  localparam int unsigned NUM_REGS = 3;

endpackage

// File: rtl/sadd_step_counter.sv
module sadd_step_counter #(
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk,
  input  logic              clear_n,
  input  logic              en,
  output logic [STEP_W-1:0] q
);

  // Toggle chain: stage i flips when enable and all lower stages are 1
  logic [STEP_W-1:0] tgl;

  assign tgl[0] = en;

  generate
    for (genvar i = 1; i < STEP_W; i++) begin : g_chain
      assign tgl[i] = tgl[i-1] & q[i-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      q <= '0;
    end else begin
      q <= q ^ tgl;
    end
  end

endmodule

// File: rtl/sadd_op_decode.sv
module sadd_op_decode
  import sadd_pkg::*;
#(
  parameter int unsigned STEP_W    = 3,
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned NUM_SLOTS = 3,
  parameter int unsigned LOAD_SLOT = 0
) (
  input  logic [STEP_W-1:0] step,
  input  logic              strobe,
  output reg_op_e           op
);

  localparam int unsigned IDX_W = STEP_W + 1;
  localparam logic [IDX_W-1:0] LOAD_IDX = IDX_W'(2 * LOAD_SLOT + 1);
  localparam logic [IDX_W-1:0] SHIFT_LO = IDX_W'(2 * NUM_SLOTS);
  localparam logic [IDX_W-1:0] SHIFT_HI = IDX_W'(2 * (NUM_SLOTS + WIDTH) - 1);

  logic [IDX_W-1:0] idx;

  assign idx = {step, strobe};

  always_comb begin
    op = OP_HOLD;
    if (idx == LOAD_IDX) begin
      op = OP_LOAD;
    end else if (idx >= SHIFT_LO && idx <= SHIFT_HI) begin
      op = OP_SHIFT;
    end
  end

endmodule

// File: rtl/sadd_shift_reg.sv
module sadd_shift_reg
  import sadd_pkg::*;
#(
  parameter int unsigned WIDTH  = 4,
  parameter bit          ROTATE = 1'b1
) (
  input  logic             clk,
  input  logic             clear_n,
  input  reg_op_e          op,
  input  logic [WIDTH-1:0] din,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q
);

  logic top_in;

  generate
    if (ROTATE) begin : g_rot
      assign top_in = q[0];
    end else begin : g_ser
      assign top_in = ser_in;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      q <= '0;
    end else begin
      case (op)
        OP_LOAD:  q <= din;
        OP_SHIFT: q <= {top_in, q[WIDTH-1:1]};
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/sadd_bit_adder.sv
module sadd_bit_adder (
  input  logic clk,
  input  logic clear_n,
  input  logic a_bit,
  input  logic b_bit,
  input  logic cap_en,
  output logic sum_bit,
  output logic carry_q
);

  logic cout;

  assign sum_bit = a_bit ^ b_bit ^ carry_q;
  assign cout    = (a_bit & b_bit) | (carry_q & (a_bit ^ b_bit));

  always_ff @(posedge clk) begin
    if (!clear_n) begin
      carry_q <= 1'b0;
    end else if (cap_en) begin
      carry_q <= cout;
    end
  end

endmodule

// File: rtl/serial_adder_seq.sv
module serial_adder_seq
  import sadd_pkg::*;
#(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned STEP_W    = 3,
  parameter int unsigned NUM_SLOTS = 3
) (
  input  logic              clk,
  input  logic              clear_n,
  input  logic              count_en,
  input  logic              load_a,
  input  logic              load_b,
  input  logic              load_c,
  input  logic [WIDTH-1:0]  data_in,
  output logic [WIDTH-1:0]  reg_a,
  output logic [WIDTH-1:0]  reg_b,
  output logic [WIDTH-1:0]  reg_c,
  output logic [STEP_W-1:0] step,
  output logic              carry_out
);

  localparam logic [STEP_W-1:0] ADD_FIRST = STEP_W'(NUM_SLOTS);
  localparam logic [STEP_W-1:0] ADD_LAST  = STEP_W'(NUM_SLOTS + WIDTH - 1);
  localparam logic [STEP_W-1:0] WIN_LAST  = STEP_W'(NUM_SLOTS + WIDTH);

  logic [NUM_REGS-1:0] strobes;
  logic [WIDTH-1:0]    regs [NUM_REGS];
  reg_op_e             ops  [NUM_REGS];
  logic                in_window;
  logic                in_add;
  logic                sum_bit;

  assign strobes = {load_c, load_b, load_a};

  sadd_step_counter #(
    .STEP_W (STEP_W)
  ) u_step (
    .clk     (clk),
    .clear_n (clear_n),
    .en      (count_en),
    .q       (step)
  );

  // Adder sees operand bits through the add steps and the final step
  assign in_window = (step >= ADD_FIRST) && (step <= WIN_LAST);
  assign in_add    = (step >= ADD_FIRST) && (step <= ADD_LAST);

  sadd_bit_adder u_add (
    .clk     (clk),
    .clear_n (clear_n),
    .a_bit   (in_window & regs[0][0]),
    .b_bit   (in_window & regs[1][0]),
    .cap_en  (in_add),
    .sum_bit (sum_bit),
    .carry_q (carry_out)
  );

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      sadd_op_decode #(
        .STEP_W    (STEP_W),
        .WIDTH     (WIDTH),
        .NUM_SLOTS (NUM_SLOTS),
        .LOAD_SLOT (r)
      ) u_dec (
        .step   (step),
        .strobe (strobes[r]),
        .op     (ops[r])
      );

      sadd_shift_reg #(
        .WIDTH  (WIDTH),
        .ROTATE (r < NUM_REGS - 1)
      ) u_reg (
        .clk     (clk),
        .clear_n (clear_n),
        .op      (ops[r]),
        .din     (data_in),
        .ser_in  (sum_bit),
        .q       (regs[r])
      );
    end
  endgenerate

  assign reg_a = regs[0];
  assign reg_b = regs[1];
  assign reg_c = regs[2];

endmodule

// File: rtl/sadd_checker.sv
module sadd_checker #(
  parameter int unsigned WIDTH     = 4,
  parameter int unsigned STEP_W    = 3,
  parameter int unsigned NUM_SLOTS = 3
) (
  input logic              clk,
  input logic              clear_n,
  input logic              count_en,
  input logic              load_a,
  input logic              load_b,
  input logic              load_c,
  input logic [WIDTH-1:0]  data_in,
  input logic [WIDTH-1:0]  reg_a,
  input logic [WIDTH-1:0]  reg_b,
  input logic [WIDTH-1:0]  reg_c,
  input logic [STEP_W-1:0] step,
  input logic              carry_out
);

  logic shifting;
  assign shifting = (step >= STEP_W'(NUM_SLOTS)) &&
                    (step <  STEP_W'(NUM_SLOTS + WIDTH));

  // R1
  p_clear_r1: assert property (@(posedge clk)
    !clear_n |=> (step == '0) && (reg_a == '0) && (reg_b == '0) &&
                 (reg_c == '0) && !carry_out);

  p_step_adv_r2: assert property (@(posedge clk) disable iff (!clear_n)
    count_en |=> step == STEP_W'($past(step) + 1'b1));

  p_step_hold_r2: assert property (@(posedge clk) disable iff (!clear_n)
    !count_en |=> $stable(step));

  p_load_a_r3: assert property (@(posedge clk) disable iff (!clear_n)
    (step == '0 && load_a) |=> reg_a == $past(data_in));

  p_load_b_r4: assert property (@(posedge clk) disable iff (!clear_n)
    (step == STEP_W'(1) && load_b) |=> reg_b == $past(data_in));

  p_load_c_r5: assert property (@(posedge clk) disable iff (!clear_n)
    (step == STEP_W'(2) && load_c) |=> reg_c == $past(data_in));

  p_rot_a_r6: assert property (@(posedge clk) disable iff (!clear_n)
    shifting |=> reg_a == {$past(reg_a[0]), $past(reg_a[WIDTH-1:1])});

  p_rot_b_r6: assert property (@(posedge clk) disable iff (!clear_n)
    shifting |=> reg_b == {$past(reg_b[0]), $past(reg_b[WIDTH-1:1])});

  p_shift_c_r7: assert property (@(posedge clk) disable iff (!clear_n)
    shifting |=> (reg_c[WIDTH-1] == $past(reg_a[0] ^ reg_b[0] ^ carry_out)) &&
                 (reg_c[WIDTH-2:0] == $past(reg_c[WIDTH-1:1])));

  p_carry_hold_r9: assert property (@(posedge clk) disable iff (!clear_n)
    !shifting |=> $stable(carry_out));

  p_final_hold_r10: assert property (@(posedge clk) disable iff (!clear_n)
    (step == STEP_W'(NUM_SLOTS + WIDTH)) |=>
      $stable(reg_a) && $stable(reg_b) && $stable(reg_c));

endmodule

bind serial_adder_seq sadd_checker #(
  .WIDTH     (WIDTH),
  .STEP_W    (STEP_W),
  .NUM_SLOTS (NUM_SLOTS)
) u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .count_en  (count_en),
  .load_a    (load_a),
  .load_b    (load_b),
  .load_c    (load_c),
  .data_in   (data_in),
  .reg_a     (reg_a),
  .reg_b     (reg_b),
  .reg_c     (reg_c),
  .step      (step),
  .carry_out (carry_out)
);

// File: tb/serial_adder_seq_tb.sv
module serial_adder_seq_tb;

  logic       clk = 1'b0;
  logic       clear_n = 1'b0;
  logic       count_en = 1'b0;
  logic       load_a = 1'b0;
  logic       load_b = 1'b0;
  logic       load_c = 1'b0;
  logic [3:0] data_in = 4'd0;
  logic [3:0] reg_a, reg_b, reg_c;
  logic [2:0] step;
  logic       carry_out;

  int checks = 0;
  int errors = 0;
  bit armed  = 1'b0;
  bit done   = 1'b0;
  int cycles = 0;

  // behavioural reference state
  int m_step = 0, m_a = 0, m_b = 0, m_c = 0, m_cy = 0;
  int n_step, n_a, n_b, n_c, n_cy, s;
  bit sh;

  always #5 clk = ~clk;

  serial_adder_seq u_dut (
    .clk       (clk),
    .clear_n   (clear_n),
    .count_en  (count_en),
    .load_a    (load_a),
    .load_b    (load_b),
    .load_c    (load_c),
    .data_in   (data_in),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .reg_c     (reg_c),
    .step      (step),
    .carry_out (carry_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!clear_n) begin
      n_step = 0; n_a = 0; n_b = 0; n_c = 0; n_cy = 0;
    end else begin
      sh = (m_step >= 3) && (m_step <= 6);
      s  = (m_a & 1) + (m_b & 1) + m_cy;
      n_a = m_a; n_b = m_b; n_c = m_c; n_cy = m_cy;
      if (m_step == 0 && load_a) n_a = data_in;
      else if (sh) n_a = (m_a >> 1) | ((m_a & 1) << 3);
      if (m_step == 1 && load_b) n_b = data_in;
      else if (sh) n_b = (m_b >> 1) | ((m_b & 1) << 3);
      if (m_step == 2 && load_c) n_c = data_in;
      else if (sh) n_c = (m_c >> 1) | ((s & 1) << 3);
      if (sh) n_cy = s >> 1;
      n_step = count_en ? (m_step + 1) % 8 : m_step;
    end
    m_step <= n_step; m_a <= n_a; m_b <= n_b; m_c <= n_c; m_cy <= n_cy;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      check("R2 step", step, m_step);
      check("R3/R6 reg_a", reg_a, m_a);
      check("R4/R6 reg_b", reg_b, m_b);
      check("R5/R7 reg_c", reg_c, m_c);
      check("R9 carry", carry_out, m_cy);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run(input int a, input int b, input bit pre_c,
                     input bit stray, input bit stall);
    clear_n = 1'b0; count_en = 1'b0;
    load_a = 1'b0; load_b = 1'b0; load_c = 1'b0; data_in = 4'(b ^ 4'hF);
    tick();
    // R1: everything zero after the clearing edge
    check("R1 clear", {reg_a, reg_b, reg_c, step, carry_out}, 0);
    clear_n = 1'b1;
    if (stall) begin
      // R3: stalled at step 0, A follows a decoy value
      load_a = 1'b1; data_in = 4'(~a);
      tick();
      check("R3 stalled load", reg_a, (~a) & 15);
      check("R2 stalled step", step, 0);
    end
    count_en = 1'b1; load_a = 1'b1; data_in = 4'(a);
    tick();
    load_a = stray; load_b = 1'b1; data_in = 4'(b);
    tick();
    check("R3 stray load_a ignored in step 1", reg_a, a);
    load_a = 1'b0; load_b = 1'b0; load_c = pre_c; data_in = 4'(a ^ b ^ 4'h5);
    tick();
    check("R10 A,B held in step 2", {reg_a, reg_b}, (a << 4) | b);
    for (int k = 0; k < 4; k++) begin
      load_a = stray; load_b = stray; load_c = stray;
      data_in = 4'($urandom_range(0, 15));
      tick();
    end
    count_en = 1'b0; load_a = 1'b0; load_b = 1'b0; load_c = 1'b0;
    check("R8 sum", reg_c, (a + b) & 15);
    check("R8 A restored", reg_a, a);
    check("R8 B restored", reg_b, b);
    check("R9 final carry", carry_out, (a + b) >> 4);
    check("R2 at step 7", step, 7);
    tick();
    tick();
    check("R9 carry held", carry_out, (a + b) >> 4);
    check("R10 C held at step 7", reg_c, (a + b) & 15);
  endtask

  initial begin
    tick();
    armed = 1'b1;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        run(a, b, ((a + b) % 3) == 0, ((a ^ b) & 1) == 1, (a % 4) == 1);
      end
    end
    // wrap: counter 7 -> 0 keeps carry until clear (R9), counter wraps (R2)
    count_en = 1'b1;
    tick();
    check("R2 wrap to 0", step, 0);
    check("R9 carry survives wrap", carry_out, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule